// File: doc/BRIEF.md
# Pixel Stream Delay Line

This block delays a pixel stream by a runtime-programmable number of pixel clocks, usually one video line, so that a pixel can be combined with the pixel directly above it. Each pixel's colour is stored together with its horizontal sync, vertical sync and active-video flags in one memory word. Colour and timing therefore leave the block together, exactly as they entered, and the block behaves like one long shift register.

The storage is a simple dual-port RAM. Each enabled clock writes the incoming word at a running address and reads the word at that address minus the delay, corrected for the one-cycle registered read. The address counter wraps modulo the RAM depth. A new delay value is sampled only at the rising edge of vertical sync, so the delay never changes in the middle of a frame. Until enough words have been written since reset, the output flags are held low, so stale RAM contents cannot show up as sync or active video.

Top module: `pix_line_delay`

## Requirements
- R1: A synchronous reset drives out_hs, out_vs and out_de low on the next clock edge and clears the write address and the fill count.
- R2: Let D be the active delay. On every clock with pix_en high, the output bundle (out_rgb, out_hs, out_vs, out_de) becomes the input bundle that was captured D enabled clocks earlier. An input captured at enabled edge k is therefore presented after enabled edge k+D-1.
- R3: While pix_en is low, no output, address or fill state changes.
- R4: While fewer than D words have been written since reset, the output flags read low and out_rgb is unspecified. From the enabled edge that completes the D-th word onward, the flags follow R2.
- R5: The active delay is reloaded from delay_cfg only on an enabled clock whose in_vs is high after an enabled clock with in_vs low (the reset value counts as low). The new delay applies from the following enabled clock. A change of delay_cfg at any other time has no effect.
- R6: A delay_cfg value below 2 acts as 2, and a value above depth minus 2 acts as depth minus 2. The depth is 2^ADDR_W.
- R7: The write and read addresses wrap modulo the depth, and the delay stays exact across any number of wraps.
- R8: During reset, the active delay is loaded from delay_cfg, clamped as in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_en | input | 1 | Advances the delay line by one pixel |
| in_rgb | input | COLOR_W | Incoming pixel colour |
| in_hs | input | 1 | Incoming horizontal sync |
| in_vs | input | 1 | Incoming vertical sync |
| in_de | input | 1 | Incoming active-video flag |
| delay_cfg | input | ADDR_W | Requested delay in pixels |
| out_rgb | output | COLOR_W | Delayed pixel colour |
| out_hs | output | 1 | Delayed horizontal sync |
| out_vs | output | 1 | Delayed vertical sync |
| out_de | output | 1 | Delayed active-video flag |

## Verification
The delay reload at a vertical-sync edge can land on the same enabled clock on which the fill count first reaches the old delay. That clock must still use the old delay and release the flags. The next clock uses the larger new delay and must pull the flags low again until the deeper fill is reached. The bench provokes this by resetting with a delay of 3 and raising in_vs on the third pixel while delay_cfg requests 10. A reference model that keeps every pixel since reset judges each output cycle by cycle. The same model covers long random runs in which delay reloads, stalls and address wraps coincide.

// File: rtl/pix_line_delay.sv
module pix_line_delay #(
  parameter int COLOR_W = 24,
  parameter int ADDR_W  = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pix_en,
  input  logic [COLOR_W-1:0] in_rgb,
  input  logic               in_hs,
  input  logic               in_vs,
  input  logic               in_de,
  input  logic [ADDR_W-1:0]  delay_cfg,
  output logic [COLOR_W-1:0] out_rgb,
  output logic               out_hs,
  output logic               out_vs,
  output logic               out_de
);
  localparam int WORD_W  = COLOR_W + 3;
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int RD_LAT  = 1;
  localparam int MIN_DLY = RD_LAT + 1;
  localparam int MAX_DLY = DEPTH - 2;
  localparam int FILL_W  = ADDR_W + 1;

  function automatic logic [ADDR_W-1:0] clamp_dly(input logic [ADDR_W-1:0] v);
    if (int'(v) < MIN_DLY)      return ADDR_W'(MIN_DLY);
    else if (int'(v) > MAX_DLY) return ADDR_W'(MAX_DLY);
    else                        return v;
  endfunction

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] rd_q;
  logic [ADDR_W-1:0] wr_ptr, act_dly, rd_addr;
  logic [FILL_W-1:0] fill, fill_nx;
  logic              vld, vs_prev, vs_rise;

  assign rd_addr = wr_ptr - (act_dly - ADDR_W'(RD_LAT));
  assign fill_nx = (fill == FILL_W'(DEPTH)) ? fill : fill + 1'b1;
  assign vs_rise = in_vs & ~vs_prev;

  always_ff @(posedge clk) begin
    if (pix_en) begin
      mem[wr_ptr] <= {in_rgb, in_hs, in_vs, in_de};
      rd_q        <= mem[rd_addr];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      fill    <= '0;
      vld     <= 1'b0;
      vs_prev <= 1'b0;
      act_dly <= clamp_dly(delay_cfg);
    end else if (pix_en) begin
      wr_ptr  <= wr_ptr + 1'b1;
      fill    <= fill_nx;
      vld     <= fill_nx >= {1'b0, act_dly};
      vs_prev <= in_vs;
      if (vs_rise) act_dly <= clamp_dly(delay_cfg);
    end
  end

  assign out_rgb = rd_q[WORD_W-1:3];
  assign out_hs  = rd_q[2] & vld;
  assign out_vs  = rd_q[1] & vld;
  assign out_de  = rd_q[0] & vld;
endmodule

// File: rtl/pix_line_delay_chk.sv
module pix_line_delay_chk #(
  parameter int COLOR_W = 24
) (
  input logic               clk,
  input logic               rst,
  input logic               pix_en,
  input logic               in_hs,
  input logic               in_vs,
  input logic               in_de,
  input logic [COLOR_W-1:0] out_rgb,
  input logic               out_hs,
  input logic               out_vs,
  input logic               out_de
);
  logic [1:0] en_cnt;
  logic seen_hs, seen_vs, seen_de;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_cnt <= '0;
      seen_hs <= 1'b0; seen_vs <= 1'b0; seen_de <= 1'b0;
    end else if (pix_en) begin
      if (en_cnt != 2'd2) en_cnt <= en_cnt + 1'b1;
      seen_hs <= seen_hs | in_hs;
      seen_vs <= seen_vs | in_vs;
      seen_de <= seen_de | in_de;
    end
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> !(out_hs || out_vs || out_de));

  a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !pix_en |=> $stable({out_rgb, out_hs, out_vs, out_de}));

  a_r4_first_gated: assert property (@(posedge clk) disable iff (rst)
    (pix_en && en_cnt == 2'd0) |=> !(out_hs || out_vs || out_de));

  a_r2_flag_origin: assert property (@(posedge clk) disable iff (rst)
    (out_hs || out_vs || out_de) |-> ((!out_hs || seen_hs) && (!out_vs || seen_vs) && (!out_de || seen_de)));
endmodule

bind pix_line_delay pix_line_delay_chk #(.COLOR_W(COLOR_W)) u_chk (
  .clk(clk), .rst(rst), .pix_en(pix_en),
  .in_hs(in_hs), .in_vs(in_vs), .in_de(in_de),
  .out_rgb(out_rgb), .out_hs(out_hs), .out_vs(out_vs), .out_de(out_de)
);

// File: tb/pix_line_delay_tb.sv
`timescale 1ns/1ps
module pix_line_delay_tb;
  localparam int AW  = 6;
  localparam int DEP = 1 << AW;
  localparam int NS  = 16384;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pix_en = 1'b0;
  logic [23:0] in_rgb = '0;
  logic in_hs = 1'b0, in_vs = 1'b0, in_de = 1'b0;
  logic [AW-1:0] delay_cfg = '0;
  logic [23:0] out_rgb;
  logic out_hs, out_vs, out_de;

  always #2.5 clk = ~clk;

  pix_line_delay #(.COLOR_W(24), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .pix_en(pix_en), .in_rgb(in_rgb),
    .in_hs(in_hs), .in_vs(in_vs), .in_de(in_de), .delay_cfg(delay_cfg),
    .out_rgb(out_rgb), .out_hs(out_hs), .out_vs(out_vs), .out_de(out_de));

  int checks = 0, errors = 0;
  bit done = 1'b0;
  string tag = "R1";

  logic [26:0] hist [NS];
  int n, act_m;
  bit vsp_m, evld;
  logic [26:0] eword;

  function automatic int clampf(int v);
    if (v < 2) return 2;
    if (v > DEP - 2) return DEP - 2;
    return v;
  endfunction

  task automatic compare();
    logic [2:0] ef, af;
    ef = evld ? eword[2:0] : 3'b000;
    af = {out_hs, out_vs, out_de};
    checks++;
    if (af !== ef) begin
      errors++;
      $display("FAIL %s flags n=%0d actual=%b expected=%b", tag, n, af, ef);
    end
    if (evld) begin
      checks++;
      if (out_rgb !== eword[26:3]) begin
        errors++;
        $display("FAIL %s rgb n=%0d actual=%h expected=%h", tag, n, out_rgb, eword[26:3]);
      end
    end
  endtask

  task automatic do_reset(int cfg);
    delay_cfg = AW'(cfg);
    rst = 1'b1; pix_en = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    n = 0; act_m = clampf(cfg); vsp_m = 1'b0; evld = 1'b0; eword = '0;
    tag = "R1";
    compare();
  endtask

  task automatic cyc(bit en, logic [23:0] rgb, bit hs, bit vs, bit de);
    logic [26:0] w;
    pix_en = en; in_rgb = rgb; in_hs = hs; in_vs = vs; in_de = de;
    w = {rgb, hs, vs, de};
    @(posedge clk);
    if (en) begin
      hist[n] = w;
      evld = (n + 1 >= act_m);
      if (n - act_m + 1 >= 0) eword = hist[n - act_m + 1];
      if (vs && !vsp_m) act_m = clampf(int'(delay_cfg));
      vsp_m = vs;
      n++;
    end
    #1 compare();
  endtask

  task automatic rnd_pix(bit vs);
    cyc(1'b1, 24'($urandom), 1'($urandom), vs, 1'($urandom));
  endtask

  initial begin
    void'($urandom(32'd4242));
    do_reset(5);
    tag = "R4";
    for (int i = 0; i < 4; i++) rnd_pix(1'b0);
    tag = "R2 R8";
    for (int i = 0; i < 30; i++) rnd_pix(1'b0);
    tag = "R3";
    for (int i = 0; i < 40; i++)
      if ($urandom_range(0, 1) == 0) cyc(1'b0, 24'($urandom), 1'b1, 1'b1, 1'b1);
      else rnd_pix(1'b0);
    tag = "R5 ignored";
    delay_cfg = 6'd20;
    for (int i = 0; i < 30; i++) rnd_pix(1'b0);
    tag = "R5 reload";
    for (int i = 0; i < 3; i++) rnd_pix(1'b1);
    for (int i = 0; i < 40; i++) rnd_pix(1'b0);
    tag = "R6 low";
    delay_cfg = 6'd0; rnd_pix(1'b1);
    for (int i = 0; i < 20; i++) rnd_pix(1'b0);
    delay_cfg = 6'd1; rnd_pix(1'b1);
    for (int i = 0; i < 20; i++) rnd_pix(1'b0);
    tag = "R6 high";
    delay_cfg = 6'd63; rnd_pix(1'b1);
    for (int i = 0; i < 150; i++) rnd_pix(1'b0);
    tag = "R7 R2 random";
    for (int i = 0; i < 3000; i++) begin
      if (i % 97 == 0) delay_cfg = AW'($urandom);
      if ($urandom_range(0, 6) == 0) cyc(1'b0, 24'($urandom), 1'b0, 1'b0, 1'b0);
      else rnd_pix($urandom_range(0, 40) == 0);
    end
    tag = "R4 R5 clash";
    do_reset(3);
    tag = "R4 R5 clash";
    rnd_pix(1'b0); rnd_pix(1'b0);
    delay_cfg = 6'd10;
    rnd_pix(1'b1);
    for (int i = 0; i < 15; i++) rnd_pix(1'b0);
    tag = "R1";
    do_reset(2);
    tag = "R4 R2 min";
    for (int i = 0; i < 10; i++) rnd_pix(1'b0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule